// File: doc/BRIEF.md
# Shared Register-Mapped Queue Bank

This block holds four shared first-in first-out queues, each 32 bits wide and 8 words deep. Four small processor cores use them through register numbers 16 to 19 of a 32-entry register file. Registers 0 to 15 stay in each core's own register file, and the block ignores any index outside the queue window. When a core reads queue register 16+q, the head word of queue q is removed and returned. When a core writes queue register 16+q, the word is appended to queue q.

An access that cannot finish holds the stall output of that core high. A read stalls while its queue is empty, and a write stalls while its queue is full. The core keeps its request asserted, and the instruction retires on the first clock edge at which the stall is low. The read data is valid in that same cycle.

Each queue has two round-robin arbiters, one for reads and one for writes, so each queue takes at most one dequeue and one enqueue per cycle. The cores that are not granted keep waiting.

Top module: `rfq_bank`

## Requirements
- R1: After reset all queues are empty, and no stall output is high while no request is active. A read of any queue register right after reset stalls.
- R2: A read of register 16+q with no stall returns the oldest word of queue q on rd_data in the same cycle, and removes that word at the next clock edge. Words leave in the order they were written.
- R3: A read of an empty queue stalls and rd_data is 0. A word written in cycle t can be read from cycle t+1 and never in cycle t, so there is no bypass.
- R4: A write to register 16+q of a queue that is not full completes without a stall, and a queue accepts 8 words.
- R5: A write to a full queue stalls. A dequeue granted in the same cycle does not let the write complete in that cycle, but the write completes in the next cycle.
- R6: On a queue that is neither empty nor full, one enqueue and one dequeue in the same cycle both complete, and the occupancy stays the same.
- R7: When several cores read, or several cores write, the same queue in one cycle, exactly one of them is granted and the rest stall. After a grant to core k, core k+1 (modulo 4) has the highest priority. After reset core 0 has the highest priority.
- R8: A read or write with an index outside 16 to 19 never stalls, returns rd_data 0 and leaves every queue unchanged.
- R9: Accesses by different cores to different queues in the same cycle all complete together.
- R10: If a core's read addresses a queue register in a cycle, its queue write in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 4 | Read request, one bit per core |
| rd_idx | input | 4x5 | Register index of each core's read |
| rd_data | output | 4x32 | Dequeued word for each core; 0 when there is no granted read |
| wr_req | input | 4 | Write request, one bit per core |
| wr_idx | input | 4x5 | Register index of each core's write |
| wr_data | input | 4x32 | Word to enqueue for each core |
| stall | output | 4 | Core must hold its access and not retire |

## Verification
Stall and rd_data are combinational from the requests and the queue state, so they are due in the cycle the request is applied. The bench drives inputs 1 ns after a rising edge and compares 1 ns later, well before the next edge. Changes in queue state (a pop, a push, the freeing of a full slot, a move of arbiter priority) are due from the cycle after the edge that commits them. For that reason every follow-up check is placed one full clock later, including the stall of a waiting writer and the grant order among cores that keep their requests held.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

   // true when a register index falls inside the queue window
   function automatic logic idx_in_window(input int idx, input int base, input int count);
      return (idx >= base) && (idx < base + count);
   endfunction

endpackage

// File: rtl/rfq_store.sv
module rfq_store #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("rfq_store: DEPTH must be a power of two, at least 2");
   end

   logic [AW:0]  wptr, rptr;
   logic [AW:0]  level;
   logic [W-1:0] slots [DEPTH];

   assign empty = (wptr == rptr);
   assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign head  = slots[rptr[AW-1:0]];
   assign level = wptr - rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) slots[wptr[AW-1:0]] <= push_data;
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_level_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> (level == $past(level)));
   assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH));

endmodule

// File: rtl/rfq_rr.sv
module rfq_rr #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("rfq_rr: N must be at least 2");
   end

   logic [IW-1:0] last, win;
   logic          found;

   always_comb begin
      gnt   = '0;
      win   = last;
      found = 1'b0;
      for (int i = 1; i <= N; i++) begin
         int k;
         k = (int'(last) + i) % N;
         if (en && req[k] && !found) begin
            gnt[k] = 1'b1;
            win    = IW'(k);
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last <= IW'(N-1);
      else if (found) last <= win;
   end

   assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   assert_blocked_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (gnt == '0));

endmodule

// File: rtl/rfq_bank.sv
module rfq_bank #(
   parameter int NCORE = 4,
   parameter int NQ    = 4,
   parameter int W     = 32,
   parameter int DEPTH = 8,
   parameter int IDXW  = 5,
   parameter int QBASE = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCORE-1:0]           rd_req,
   input  logic [NCORE-1:0][IDXW-1:0] rd_idx,
   output logic [NCORE-1:0][W-1:0]    rd_data,
   input  logic [NCORE-1:0]           wr_req,
   input  logic [NCORE-1:0][IDXW-1:0] wr_idx,
   input  logic [NCORE-1:0][W-1:0]    wr_data,
   output logic [NCORE-1:0]           stall
);
   import rfq_pkg::*;

   localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

   if (NCORE < 2)                    begin : g_bad_cores
      $error("rfq_bank: NCORE must be at least 2");
   end
   if (NQ < 1 || QBASE < 0 || QBASE + NQ > (1 << IDXW)) begin : g_bad_window
      $error("rfq_bank: queue window does not fit the register index");
   end

   logic [NCORE-1:0]         rd_hit, wr_hit, rd_ok, wr_ok;
   logic [NCORE-1:0][QW-1:0] rd_q, wr_q;
   logic [NQ-1:0][NCORE-1:0] rreq, wreq, rgnt, wgnt;
   logic [NQ-1:0][W-1:0]     head;
   logic [NQ-1:0]            q_empty, q_full;

   // index decode; a queue read takes precedence over a queue write
   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         rd_hit[c] = rd_req[c] && idx_in_window(int'(rd_idx[c]), QBASE, NQ);
         wr_hit[c] = wr_req[c] && !rd_hit[c] && idx_in_window(int'(wr_idx[c]), QBASE, NQ);
         rd_q[c]   = QW'(int'(rd_idx[c]) - QBASE);
         wr_q[c]   = QW'(int'(wr_idx[c]) - QBASE);
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_queue
      logic [W-1:0] pdata;

      always_comb begin
         for (int c = 0; c < NCORE; c++) begin
            rreq[q][c] = rd_hit[c] && (rd_q[c] == QW'(q));
            wreq[q][c] = wr_hit[c] && (wr_q[c] == QW'(q));
         end
      end

      rfq_rr #(.N(NCORE)) u_rd_arb (
         .clk(clk), .rst_n(rst_n), .en(!q_empty[q]), .req(rreq[q]), .gnt(rgnt[q]));
      rfq_rr #(.N(NCORE)) u_wr_arb (
         .clk(clk), .rst_n(rst_n), .en(!q_full[q]), .req(wreq[q]), .gnt(wgnt[q]));

      always_comb begin
         pdata = '0;
         for (int c = 0; c < NCORE; c++) begin
            if (wgnt[q][c]) pdata = wr_data[c];
         end
      end

      rfq_store #(.W(W), .DEPTH(DEPTH)) u_store (
         .clk(clk), .rst_n(rst_n),
         .push(|wgnt[q]), .push_data(pdata),
         .pop(|rgnt[q]), .head(head[q]),
         .empty(q_empty[q]), .full(q_full[q]));
   end

   always_comb begin
      for (int c = 0; c < NCORE; c++) begin
         rd_ok[c] = 1'b0;
         wr_ok[c] = 1'b0;
         for (int q = 0; q < NQ; q++) begin
            rd_ok[c] = rd_ok[c] | rgnt[q][c];
            wr_ok[c] = wr_ok[c] | wgnt[q][c];
         end
         stall[c]   = (rd_hit[c] && !rd_ok[c]) || (wr_hit[c] && !wr_ok[c]);
         rd_data[c] = rd_ok[c] ? head[rd_q[c]] : '0;
      end
   end

   for (genvar c = 0; c < NCORE; c++) begin : g_core_chk
      assert_stall_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
         stall[c] |-> (rd_req[c] || wr_req[c]));
      assert_foreign_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_req[c] && !idx_in_window(int'(rd_idx[c]), QBASE, NQ)) |-> (rd_data[c] == '0));
      assert_stalled_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_hit[c] && stall[c]) |-> (rd_data[c] == '0));
   end

endmodule

// File: tb/rfq_bank_test.sv
`timescale 1ns/1ps
module rfq_bank_test;
   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [3:0]           rd_req, wr_req;
   logic [3:0][4:0]      rd_idx, wr_idx;
   logic [3:0][31:0]     wr_data;
   logic [3:0][31:0]     rd_data;
   logic [3:0]           stall;
   int                   n_cmp = 0;
   int                   n_bad = 0;

   always #2.5 clk = ~clk;

   rfq_bank uut (
      .clk(clk), .rst_n(rst_n),
      .rd_req(rd_req), .rd_idx(rd_idx), .rd_data(rd_data),
      .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
      .stall(stall));

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic idle();
      rd_req = '0; wr_req = '0; rd_idx = '0; wr_idx = '0; wr_data = '0;
   endtask

   task automatic rd(input int c, input int q);
      rd_req[c] = 1'b1; rd_idx[c] = 5'(16 + q);
   endtask

   task automatic wr(input int c, input int q, input logic [31:0] d);
      wr_req[c] = 1'b1; wr_idx[c] = 5'(16 + q); wr_data[c] = d;
   endtask

   task automatic nxt();
      @(posedge clk); #1;
   endtask

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: idle after reset, read of empty queue stalls
      #1 chk("R1 idle stall", 32'(stall), 32'h0);
      rd(0, 0); #1;
      chk("R1 read after reset stalls", 32'(stall[0]), 32'h1);
      chk("R3 stalled read data", rd_data[0], 32'h0);
      nxt();

      // R4: fill queue 0 with 8 words
      for (int i = 0; i < 8; i++) begin
         idle(); wr(0, 0, 32'hA000 + i); #1;
         chk("R4 write with space", 32'(stall[0]), 32'h0);
         nxt();
      end
      // R5: write to full queue stalls
      idle(); wr(0, 0, 32'hA008); #1;
      chk("R5 full write stalls", 32'(stall[0]), 32'h1);
      nxt();
      idle(); wr(0, 0, 32'hA008); rd(1, 0); #1;
      chk("R5 same-cycle dequeue does not free", 32'(stall[0]), 32'h1);
      chk("R2 read no stall", 32'(stall[1]), 32'h0);
      chk("R2 head word", rd_data[1], 32'hA000);
      nxt();
      idle(); wr(0, 0, 32'hA008); #1;
      chk("R5 write completes next cycle", 32'(stall[0]), 32'h0);
      nxt();

      // R2: drain in order
      for (int i = 1; i <= 8; i++) begin
         idle(); rd(1, 0); #1;
         chk("R2 drain stall", 32'(stall[1]), 32'h0);
         chk("R2 drain order", rd_data[1], 32'hA000 + i);
         nxt();
      end
      // R3: no bypass
      idle(); rd(1, 0); wr(2, 0, 32'hBEEF); #1;
      chk("R3 empty read stalls", 32'(stall[1]), 32'h1);
      chk("R4 write to empty", 32'(stall[2]), 32'h0);
      chk("R3 no bypass data", rd_data[1], 32'h0);
      nxt();
      idle(); rd(1, 0); #1;
      chk("R3 word ready next cycle", 32'(stall[1]), 32'h0);
      chk("R3 word value", rd_data[1], 32'hBEEF);
      nxt();

      // R6: concurrent push and pop on queue 1
      for (int i = 0; i < 3; i++) begin
         idle(); wr(0, 1, 32'hC000 + i); nxt();
      end
      idle(); wr(0, 1, 32'hC003); rd(1, 1); #1;
      chk("R6 push side", 32'(stall[0]), 32'h0);
      chk("R6 pop side", 32'(stall[1]), 32'h0);
      chk("R6 pop data", rd_data[1], 32'hC000);
      nxt();
      for (int i = 1; i <= 3; i++) begin
         idle(); rd(1, 1); #1;
         chk("R6 remaining data", rd_data[1], 32'hC000 + i);
         nxt();
      end
      idle(); rd(1, 1); #1;
      chk("R6 occupancy unchanged", 32'(stall[1]), 32'h1);
      nxt();

      // R7: four writers contend for queue 2
      idle();
      for (int c = 0; c < 4; c++) wr(c, 2, 32'h200 + c);
      for (int k = 0; k < 4; k++) begin
         #1;
         for (int c = k; c < 4; c++)
            chk("R7 writer grant order", 32'(stall[c]), (c == k) ? 32'h0 : 32'h1);
         nxt();
         wr_req[k] = 1'b0;
      end
      for (int i = 0; i < 4; i++) begin
         idle(); rd(0, 2); #1;
         chk("R7 write order", rd_data[0], 32'h200 + i);
         nxt();
      end

      // R7: reader rotation on queue 3
      for (int i = 0; i < 5; i++) begin
         idle(); wr(0, 3, 32'hD000 + i); nxt();
      end
      idle(); rd(2, 3); #1;
      chk("R7 single reader", rd_data[2], 32'hD000);
      nxt();
      idle(); rd(0, 3); rd(1, 3); rd(3, 3);
      for (int s = 0; s < 3; s++) begin
         int g;
         g = (s == 0) ? 3 : s - 1;
         #1;
         chk("R7 rotated grant", 32'(stall[g]), 32'h0);
         chk("R7 rotated data", rd_data[g], 32'hD001 + s);
         chk("R7 others wait", 32'(stall & rd_req), 32'(rd_req & ~(4'b1 << g)));
         nxt();
         rd_req[g] = 1'b0;
      end

      // R8: indices outside the window
      idle();
      rd_req[0] = 1'b1; rd_idx[0] = 5'd5;
      wr_req[1] = 1'b1; wr_idx[1] = 5'd20; wr_data[1] = 32'h1234;
      rd_req[2] = 1'b1; rd_idx[2] = 5'd15;
      wr_req[3] = 1'b1; wr_idx[3] = 5'd15; wr_data[3] = 32'h5678;
      #1;
      chk("R8 no stall", 32'(stall), 32'h0);
      chk("R8 read data zero", rd_data[0], 32'h0);
      chk("R8 read data zero", rd_data[2], 32'h0);
      nxt();
      idle(); rd(0, 3); #1;
      chk("R8 queue unchanged", rd_data[0], 32'hD004);
      nxt();
      for (int q = 0; q < 4; q++) begin
         idle(); rd(0, q); #1;
         chk("R8 queues left empty", 32'(stall[0]), 32'h1);
         nxt();
      end

      // R9: parallel independent queues
      idle();
      for (int c = 0; c < 4; c++) wr(c, c, 32'hE000 + c);
      #1 chk("R9 parallel writes", 32'(stall), 32'h0);
      nxt();
      idle();
      for (int c = 0; c < 4; c++) rd(c, (c + 1) % 4);
      #1 chk("R9 parallel reads", 32'(stall), 32'h0);
      for (int c = 0; c < 4; c++)
         chk("R9 parallel data", rd_data[c], 32'hE000 + ((c + 1) % 4));
      nxt();

      // R10: queue write ignored when same core reads a queue
      idle(); wr(1, 0, 32'hF00D); nxt();
      idle(); rd(0, 0); wr(0, 1, 32'h0BAD); #1;
      chk("R10 read completes", 32'(stall[0]), 32'h0);
      chk("R10 read data", rd_data[0], 32'hF00D);
      nxt();
      idle(); rd(1, 1); #1;
      chk("R10 write was ignored", 32'(stall[1]), 32'h1);
      nxt();
      idle();

      summary();
      $finish;
   end
endmodule